// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This block is a word-addressed, unified cache between a processor request port and a word-wide memory port. A processor load or store is accepted with a valid/ready handshake. The request address is split into three fields. The low log2(block size) bits give the word offset, the next log2(sets) bits give the set, and the remaining bits form the tag. A hit is served directly from the cache. On a miss the controller first chooses a victim way in the set and evicts it. It then fetches the whole target block one word per cycle and serves the request from the newly filled line.

Stores use write-back with write-allocate. A store miss first fills the block and then writes the word into the cache, which marks the line dirty. When a victim is needed, an empty way is taken first. If every way in the set holds a block, the least-recently-used way is replaced. A dirty victim is written back to memory in full. A clean victim is dropped.

For every data movement the controller raises a transfer event on a dedicated output. The event gives the kind of transfer, the starting word address and the length in words, so a monitor can log each access as a strict sequence: eviction, fill, then the processor transfer. Block size, set count and ways per set are parameters, each a power of two.

Top module: `wbcache_ctrl`

## Requirements
- R1: After reset, and again after any later reset, `req_ready_o` is 1 and `rsp_valid_o` and `evt_valid_o` are 0. Reset invalidates every line and clears every dirty bit, so data held only in the cache is lost and the next access to that block misses with no eviction.
- R2: On a read hit, data comes back from the cache with `rsp_valid_o`. The only event is a serve event of kind 0 (cache to processor) at the exact word address with length 1. No memory access takes place.
- R3: On a miss with an empty way in the set, no eviction event occurs. A fill event of kind 2 (memory to cache) is raised with the block-aligned address (offset bits cleared) and length equal to the block size. A serve event follows. Set and tag come from the address fields described above.
- R4: When a set has an empty way, a miss fills that way instead of evicting a valid block.
- R5: When every way of the set is valid, the least-recently-used way is replaced. Every hit and every fill makes the accessed way the most recently used.
- R6: A dirty victim raises an event of kind 3 (cache to memory) with the victim's block address and length equal to the block size. It also performs exactly block-size memory writes carrying the whole block, so a later miss on that block reads back the stored data.
- R7: A clean victim raises an event of kind 4 (cache to nowhere) with its block address and the block length, and performs no memory write.
- R8: A store, whether it hits or misses after the fill, writes its word into the cache and raises a serve event of kind 1 (processor to cache) at that word with length 1. A later read of that word returns the stored value.
- R9: Events for one access come in a fixed order: at most one eviction, then at most one fill, then exactly one serve event. The serve event coincides with `rsp_valid_o`. `req_ready_o` stays low from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Controller idle and accepting a request |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | WORD_W | Store data |
| rsp_valid_o | output | 1 | Response cycle of the accepted access |
| rsp_rdata_o | output | WORD_W | Load data, valid with rsp_valid_o on loads |
| mem_we_o | output | 1 | Write one word to memory this cycle |
| mem_re_o | output | 1 | Read one word from memory this cycle |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | WORD_W | Memory write data |
| mem_rdata_i | input | WORD_W | Memory read data for mem_addr_o, same cycle |
| evt_valid_o | output | 1 | Transfer event valid |
| evt_kind_o | output | 3 | 0 cache-to-processor, 1 processor-to-cache, 2 memory-to-cache, 3 cache-to-memory, 4 cache-to-nowhere |
| evt_addr_o | output | ADDR_W | Start word address of the transfer |
| evt_len_o | output | LEN_W | Transfer length in words |

## Verification
The bench walks a sequence of accesses that move the two-way sets through every victim case. It covers:
- **Empty way first.** A design that ignored valid bits in victim choice would evict a live block, which shows up as an unexpected discard.
- **Recency refreshed on hits.** A design that updated LRU only on fills would pick the wrong victim after a hit.
- **Dirty write-back.** Blocks written back are later re-read, so a short burst or wrong data in the write-back returns stale values.
- **Clean discard.** A clean victim is checked for a drop event with no memory writes, so a design that wrote back unconditionally is caught.
- **Store-miss allocation.** A design that skipped the fill would emit the wrong event sequence.
- **Reset mid-run.** A reset with dirty lines present must drop them without any write-back, which catches dirty bits that survive reset.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    EV_C2P  = 3'd0,
    EV_P2C  = 3'd1,
    EV_M2C  = 3'd2,
    EV_C2M  = 3'd3,
    EV_DROP = 3'd4
  } evt_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_RESP
  } ctrl_state_e;
endpackage

// File: rtl/wbc_addr_split.sv
module wbc_addr_split #(
  parameter int ADDR_W   = 16,
  parameter int OFF_BITS = 2,
  parameter int IDX_BITS = 1,
  parameter int OFF_W    = 2,
  parameter int IDX_W    = 1,
  parameter int TAG_W    = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OFF_W-1:0]  off_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_BITS) - 1);
  localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'((1 << IDX_BITS) - 1);

  logic [ADDR_W-1:0] off_full, idx_full, tag_full;

  always_comb begin
    off_full = addr_i & OFF_MASK;
    idx_full = (addr_i >> OFF_BITS) & IDX_MASK;
    tag_full = addr_i >> (OFF_BITS + IDX_BITS);
    off_o    = off_full[OFF_W-1:0];
    idx_o    = idx_full[IDX_W-1:0];
    tag_o    = tag_full[TAG_W-1:0];
  end
endmodule

// File: rtl/wbc_lru.sv
// Per-set age counters: 0 = most recent, NUM_WAYS-1 = least recent.
module wbc_lru #(
  parameter int NUM_SETS = 2,
  parameter int NUM_WAYS = 2,
  parameter int IDX_W    = 1,
  parameter int WAY_W    = 1,
  parameter int AGE_W    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [IDX_W-1:0] query_set_i,
  output logic [WAY_W-1:0] lru_way_o
);
  logic [AGE_W-1:0] age_q [NUM_SETS][NUM_WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way_o = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (age_q[query_set_i][w] == AGE_W'(NUM_WAYS - 1))
        lru_way_o = WAY_W'(w);
  end
endmodule

// File: rtl/wbc_victim.sv
// Lowest-numbered empty way wins; otherwise the LRU way.
module wbc_victim #(
  parameter int NUM_WAYS = 2,
  parameter int WAY_W    = 1
) (
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [WAY_W-1:0]    lru_way_i,
  output logic [WAY_W-1:0]    way_o
);
  always_comb begin
    way_o = lru_way_i;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) way_o = WAY_W'(w);
  end
endmodule

// File: rtl/wbcache_ctrl.sv
module wbcache_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WORD_W      = 32,
  parameter int BLOCK_WORDS = 4,
  parameter int NUM_SETS    = 2,
  parameter int NUM_WAYS    = 2,
  parameter int LEN_W       = $clog2(BLOCK_WORDS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_rdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              evt_valid_o,
  output logic [2:0]        evt_kind_o,
  output logic [ADDR_W-1:0] evt_addr_o,
  output logic [LEN_W-1:0]  evt_len_o
);
  localparam int OFF_BITS = $clog2(BLOCK_WORDS);
  localparam int IDX_BITS = $clog2(NUM_SETS);
  localparam int WAY_BITS = $clog2(NUM_WAYS);
  localparam int OFF_W    = (OFF_BITS > 0) ? OFF_BITS : 1;
  localparam int IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
  localparam int WAY_W    = (WAY_BITS > 0) ? WAY_BITS : 1;
  localparam int AGE_W    = WAY_W;
  localparam int TAG_W    = ADDR_W - OFF_BITS - IDX_BITS;
  localparam int LINES    = NUM_SETS * NUM_WAYS;
  localparam int LINE_W   = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int WORDS    = LINES * BLOCK_WORDS;
  localparam int DIDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CNT_W    = OFF_BITS + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLOCK_WORDS - 1);

  ctrl_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WAY_W-1:0]  way_q;
  logic [CNT_W-1:0]  cnt_q;

  logic              valid_q [LINES];
  logic              dirty_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [WORD_W-1:0] data_q  [WORDS];

  logic [OFF_W-1:0]    off_c;
  logic [IDX_W-1:0]    idx_c;
  logic [TAG_W-1:0]    tag_c;
  logic                hit_c;
  logic [WAY_W-1:0]    hit_way_c;
  logic [NUM_WAYS-1:0] set_valid_c;
  logic [WAY_W-1:0]    lru_way_c;
  logic [WAY_W-1:0]    vic_way_c;
  logic [LINE_W-1:0]   line_c;
  logic [DIDX_W-1:0]   burst_idx_c;
  logic [DIDX_W-1:0]   word_idx_c;
  logic [ADDR_W-1:0]   blk_addr_c;
  logic [ADDR_W-1:0]   vic_addr_c;
  logic                touch_c;

  wbc_addr_split #(
    .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .IDX_BITS(IDX_BITS),
    .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_split (
    .addr_i(addr_q), .off_o(off_c), .idx_o(idx_c), .tag_o(tag_c)
  );

  always_comb begin
    hit_c     = 1'b0;
    hit_way_c = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      set_valid_c[w] = valid_q[LINE_W'(int'(idx_c) * NUM_WAYS + w)];
      if (set_valid_c[w] && tag_q[LINE_W'(int'(idx_c) * NUM_WAYS + w)] == tag_c) begin
        hit_c     = 1'b1;
        hit_way_c = WAY_W'(w);
      end
    end
  end

  assign touch_c = (state_q == ST_RESP);

  wbc_lru #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS),
    .IDX_W(IDX_W), .WAY_W(WAY_W), .AGE_W(AGE_W)
  ) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .touch_i(touch_c), .touch_set_i(idx_c), .touch_way_i(way_q),
    .query_set_i(idx_c), .lru_way_o(lru_way_c)
  );

  wbc_victim #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_victim (
    .valid_i(set_valid_c), .lru_way_i(lru_way_c), .way_o(vic_way_c)
  );

  always_comb begin
    line_c      = LINE_W'(int'(idx_c) * NUM_WAYS + int'(way_q));
    burst_idx_c = DIDX_W'(int'(line_c) * BLOCK_WORDS + int'(cnt_q));
    word_idx_c  = DIDX_W'(int'(line_c) * BLOCK_WORDS + int'(off_c));
    blk_addr_c  = addr_q & ~ADDR_W'(BLOCK_WORDS - 1);
    vic_addr_c  = (ADDR_W'(tag_q[line_c]) << (OFF_BITS + IDX_BITS))
                | (ADDR_W'(idx_c) << OFF_BITS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      way_q   <= '0;
      cnt_q   <= '0;
      for (int l = 0; l < LINES; l++) begin
        valid_q[l] <= 1'b0;
        dirty_q[l] <= 1'b0;
      end
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          we_q    <= req_write_i;
          wdata_q <= req_wdata_i;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          cnt_q <= '0;
          if (hit_c) begin
            way_q   <= hit_way_c;
            state_q <= ST_RESP;
          end else begin
            way_q   <= vic_way_c;
            state_q <= set_valid_c[vic_way_c] ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: begin
          if (!dirty_q[line_c] || cnt_q == CNT_LAST) begin
            valid_q[line_c] <= 1'b0;
            dirty_q[line_c] <= 1'b0;
            cnt_q           <= '0;
            state_q         <= ST_FILL;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FILL: begin
          if (cnt_q == CNT_LAST) begin
            valid_q[line_c] <= 1'b1;
            dirty_q[line_c] <= 1'b0;
            cnt_q           <= '0;
            state_q         <= ST_RESP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RESP: begin
          if (we_q) dirty_q[line_c] <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Payload arrays carry no reset; valid bits gate their use.
  always_ff @(posedge clk_i) begin
    if (state_q == ST_FILL) begin
      data_q[burst_idx_c] <= mem_rdata_i;
      if (cnt_q == CNT_LAST) tag_q[line_c] <= tag_c;
    end
    if (state_q == ST_RESP && we_q) data_q[word_idx_c] <= wdata_q;
  end

  always_comb begin
    req_ready_o = (state_q == ST_IDLE);
    rsp_valid_o = (state_q == ST_RESP);
    rsp_rdata_o = (state_q == ST_RESP && !we_q) ? data_q[word_idx_c] : '0;

    mem_we_o    = (state_q == ST_EVICT) && dirty_q[line_c];
    mem_re_o    = (state_q == ST_FILL);
    mem_addr_o  = (state_q == ST_EVICT) ? vic_addr_c + ADDR_W'(cnt_q)
                                        : blk_addr_c + ADDR_W'(cnt_q);
    mem_wdata_o = data_q[burst_idx_c];

    evt_valid_o = 1'b0;
    evt_kind_o  = EV_C2P;
    evt_addr_o  = '0;
    evt_len_o   = '0;
    if (state_q == ST_EVICT && cnt_q == '0) begin
      evt_valid_o = 1'b1;
      evt_kind_o  = dirty_q[line_c] ? EV_C2M : EV_DROP;
      evt_addr_o  = vic_addr_c;
      evt_len_o   = LEN_W'(BLOCK_WORDS);
    end else if (state_q == ST_FILL && cnt_q == '0) begin
      evt_valid_o = 1'b1;
      evt_kind_o  = EV_M2C;
      evt_addr_o  = blk_addr_c;
      evt_len_o   = LEN_W'(BLOCK_WORDS);
    end else if (state_q == ST_RESP) begin
      evt_valid_o = 1'b1;
      evt_kind_o  = we_q ? EV_P2C : EV_C2P;
      evt_addr_o  = addr_q;
      evt_len_o   = LEN_W'(1);
    end
  end
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_WORDS = 4,
  parameter int LEN_W       = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              evt_valid_o,
  input logic [2:0]        evt_kind_o,
  input logic [ADDR_W-1:0] evt_addr_o,
  input logic [LEN_W-1:0]  evt_len_o
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLOCK_WORDS - 1);

  // R9: kinds outside the five defined codes never appear
  a_r9_kind_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> evt_kind_o <= 3'd4);

  // R9: response cycle carries exactly the serve event of length 1
  a_r9_serve_with_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> evt_valid_o && evt_kind_o <= 3'd1 && evt_len_o == LEN_W'(1));

  // R3: fill events are block aligned and one block long
  a_r3_fill_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == 3'd2)
      |-> (evt_addr_o & OFF_MASK) == '0 && evt_len_o == LEN_W'(BLOCK_WORDS));

  // R6: memory writes happen only while busy, never alongside a response
  a_r6_wb_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !req_ready_o && !rsp_valid_o && !mem_re_o);

  // R9: an accepted request blocks the port on the next cycle
  a_r9_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R1: an idle controller reports no event
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !evt_valid_o && !rsp_valid_o);
endmodule

bind wbcache_ctrl wbc_checker #(
  .ADDR_W(ADDR_W), .BLOCK_WORDS(BLOCK_WORDS), .LEN_W(LEN_W)
) u_wbc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .evt_valid_o(evt_valid_o),
  .evt_kind_o(evt_kind_o), .evt_addr_o(evt_addr_o), .evt_len_o(evt_len_o)
);

// File: tb/wbcache_ctrl_test.sv
`timescale 1ns/1ps
module wbcache_ctrl_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          evt_valid;
  logic [2:0]    evt_kind;
  logic [AW-1:0] evt_addr;
  logic [LW-1:0] evt_len;

  always #10 clk = ~clk;

  wbcache_ctrl #(.ADDR_W(AW), .WORD_W(DW), .BLOCK_WORDS(4),
                 .NUM_SETS(2), .NUM_WAYS(2)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .evt_valid_o(evt_valid), .evt_kind_o(evt_kind),
    .evt_addr_o(evt_addr), .evt_len_o(evt_len)
  );

  logic [DW-1:0] mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // ev: 0 none, 1 dirty write-back, 2 clean discard
  typedef struct packed {
    logic [3:0]  rq;
    logic        we;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [1:0]  ev;
    logic [15:0] ev_addr;
    logic        fill;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd3, 1'b0, 16'd0,  32'h0,  32'h1000, 2'd0, 16'd0,  1'b1}, // R3 cold fill
    '{4'd8, 1'b1, 16'd6,  32'hAA, 32'h0,    2'd0, 16'd0,  1'b1}, // R8 store miss allocates
    '{4'd2, 1'b0, 16'd1,  32'h0,  32'h1001, 2'd0, 16'd0,  1'b0}, // R2 read hit
    '{4'd4, 1'b0, 16'd9,  32'h0,  32'h1009, 2'd0, 16'd0,  1'b1}, // R4 empty way used
    '{4'd5, 1'b0, 16'd2,  32'h0,  32'h1002, 2'd0, 16'd0,  1'b0}, // R5 hit refreshes block 0
    '{4'd7, 1'b0, 16'd16, 32'h0,  32'h1010, 2'd2, 16'd8,  1'b1}, // R7 clean LRU dropped
    '{4'd4, 1'b0, 16'd22, 32'h0,  32'h1016, 2'd0, 16'd0,  1'b1}, // R4 second way of set 1
    '{4'd6, 1'b0, 16'd13, 32'h0,  32'h100D, 2'd1, 16'd4,  1'b1}, // R6 dirty LRU written back
    '{4'd6, 1'b0, 16'd6,  32'h0,  32'hAA,   2'd2, 16'd20, 1'b1}, // R6 written-back word read
    '{4'd8, 1'b1, 16'd3,  32'hBB, 32'h0,    2'd0, 16'd0,  1'b0}, // R8 store hit
    '{4'd8, 1'b1, 16'd17, 32'hCC, 32'h0,    2'd0, 16'd0,  1'b0}, // R8 store hit other way
    '{4'd6, 1'b1, 16'd8,  32'hDD, 32'h0,    2'd1, 16'd0,  1'b1}, // R6 store miss evicts dirty
    '{4'd6, 1'b0, 16'd3,  32'h0,  32'hBB,   2'd1, 16'd16, 1'b1}, // R6 both dirty evictions
    '{4'd8, 1'b0, 16'd8,  32'h0,  32'hDD,   2'd0, 16'd0,  1'b0}, // R8 allocated store visible
    '{4'd5, 1'b0, 16'd17, 32'h0,  32'hCC,   2'd2, 16'd0,  1'b1}  // R5 LRU after hits
  };

  logic [2:0]    lk [4];
  logic [AW-1:0] la [4];
  logic [LW-1:0] ll [4];
  int            nev, nwr;
  logic [DW-1:0] got_rd;
  bit            got;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    nev = 0; nwr = 0; got = 0; got_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (evt_valid) begin
        if (nev < 4) begin lk[nev] = evt_kind; la[nev] = evt_addr; ll[nev] = evt_len; end
        nev++;
      end
      if (mem_we) nwr++;
      if (rsp_valid) begin got = 1; got_rd = rsp_rdata; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int  ne;
    logic [2:0]    ek [3];
    logic [AW-1:0] ea [3];
    logic [LW-1:0] el [3];
    string tag;
    tag = $sformatf("R%0d/R9 addr %0d", v.rq, v.addr);
    ne = 0;
    if (v.ev != 0) begin
      ek[ne] = (v.ev == 2'd1) ? 3'd3 : 3'd4; ea[ne] = v.ev_addr; el[ne] = 3'd4; ne++;
    end
    if (v.fill) begin
      ek[ne] = 3'd2; ea[ne] = v.addr & ~16'd3; el[ne] = 3'd4; ne++;
    end
    ek[ne] = v.we ? 3'd1 : 3'd0; ea[ne] = v.addr; el[ne] = 3'd1; ne++;
    access(v.we, v.addr, v.wdata);
    check(got, {tag, " response seen"}, 32'(got), 32'd1);
    check(nev == ne, {tag, " event count"}, 32'(nev), 32'(ne));
    for (int i = 0; i < ne && i < nev; i++) begin
      check(lk[i] == ek[i] && la[i] == ea[i] && ll[i] == el[i],
            $sformatf("%s event %0d kind/addr/len", tag, i),
            {13'd0, lk[i], la[i]}, {13'd0, ek[i], ea[i]});
    end
    // R6 whole-block write-back, R7 none for clean victims
    check(nwr == ((v.ev == 2'd1) ? 4 : 0), {tag, " memory writes R6/R7"},
          32'(nwr), (v.ev == 2'd1) ? 32'd4 : 32'd0);
    if (!v.we) check(got_rd == v.rdata, {tag, " read data"}, got_rd, v.rdata);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000 + 32'(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0 && evt_valid == 1'b0, "R1 quiet in reset",
          {30'd0, rsp_valid, evt_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && !evt_valid, "R1 idle after reset", 32'(req_ready), 32'd1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R6 written-back data reached memory
    check(mem[6] == 32'hAA, "R6 memory word 6", mem[6], 32'hAA);
    check(mem[3] == 32'hBB, "R6 memory word 3", mem[3], 32'hBB);

    // R1 reset drops dirty block 8 without write-back
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1 && !rsp_valid, "R1 ready after second reset",
          32'(req_ready), 32'd1);
    rst_n = 1'b1;
    run_vec('{4'd1, 1'b0, 16'd8, 32'h0, 32'h1008, 2'd0, 16'd0, 1'b1});
    check(mem[8] == 32'h1008, "R1 dirty data not written", mem[8], 32'h1008);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule